// File: doc/BRIEF.md
# Block Memory Copy Engine

This block moves a run of bytes from one region of a byte-wide memory to another. Three architected registers drive it: a source pointer, a destination pointer and a byte counter. Software or a surrounding controller loads them through a small load port and then pulses a start input, choosing a repeat or single mode and an ascending or descending direction. Each transfer step is a read cycle at the source pointer followed by a write cycle of the same byte at the destination pointer. Both cycles complete on a ready handshake from the memory.

After each step the two pointers move by one in the chosen direction and the counter drops by one. In single mode the engine stops after one step. In repeat mode it keeps stepping until the counter reaches zero. All three registers stay readable after the copy, so a caller can resume or chain transfers. A status flag tells whether the counter is nonzero. A one-cycle done pulse and a busy level frame each run.

Top module: `blkcopy_engine`

## Requirements
- R1: While the engine is idle, `ld_en` writes `ld_val` into the register that `ld_sel` selects (0 = source pointer, 1 = destination pointer, 2 = byte counter, 3 = none) at the next clock edge. A load presented while `busy` is high leaves all three registers unchanged.
- R2: Each step drives one read (`mem_rd`) at the source pointer and then one write (`mem_wr`) at the destination pointer. The write data equals the byte returned by the read. The engine issues no write to the source address, and read and write are never active together.
- R3: In ascending mode each completed step adds one to both pointers, modulo 2^ADDR_W, and subtracts one from the counter, modulo 2^CNT_W.
- R4: In descending mode each completed step subtracts one from both pointers, modulo 2^ADDR_W. The counter still drops by one.
- R5: With `rep_mode` low at start, exactly one step is made, whatever the counter value. A zero counter becomes all ones.
- R6: With `rep_mode` high at start, steps continue until the counter is zero. A counter of zero at start wraps and copies 2^CNT_W bytes.
- R7: `cnt_nz` is low after reset. After each step it shows whether the counter is nonzero. After a counter load it shows whether the loaded value is nonzero.
- R8: A read or write cycle holds its strobe and address until `mem_rdy` is high at a clock edge. The read data is taken on that edge.
- R9: A `start` pulse while `busy` is high is ignored. The running transfer keeps its original mode and direction.
- R10: `busy` rises on the edge that accepts `start` and falls on the edge that completes the last write. `done` is high for exactly that one following cycle.
- R11: After reset the pointers and counter are zero and `busy`, `done`, `cnt_nz`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 2 | Load target: 0 source, 1 destination, 2 counter, 3 none |
| ld_val | input | LD_W | Load value, the wider of ADDR_W and CNT_W |
| start | input | 1 | Start pulse |
| rep_mode | input | 1 | 1 repeat until counter zero, 0 single step |
| desc_mode | input | 1 | 1 descending addresses, 0 ascending |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Read cycle strobe |
| mem_wr | output | 1 | Write cycle strobe |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data |
| mem_rdy | input | 1 | Memory ready, completes the current cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cnt_nz | output | 1 | Counter nonzero flag |
| src_ptr | output | ADDR_W | Source pointer |
| dst_ptr | output | ADDR_W | Destination pointer |
| byte_cnt | output | CNT_W | Byte counter |

## Verification
The bench builds the engine with ADDR_W = 10, CNT_W = 8 and DATA_W = 8, with the ready handshake enabled. The narrow address makes a 1024-byte memory model practical and lets descending and ascending runs wrap across both address ends. The 8-bit counter turns the zero-count wrap into a 256-byte run that fits well inside the run budget. A ready model with zero to three wait cycles, together with overlapping source and destination regions, exercises the handshake and the strict step-by-step ordering of reads and writes.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } seq_state_e;

   localparam logic [1:0] SEL_SRC = 2'd0;
   localparam logic [1:0] SEL_DST = 2'd1;
   localparam logic [1:0] SEL_CNT = 2'd2;

endpackage

// File: rtl/blkcopy_regs.sv
module blkcopy_regs
   import blkcopy_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int LD_W   = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [1:0]        ld_sel,
   input  logic [LD_W-1:0]   ld_val,
   input  logic              step,
   input  logic              desc,
   output logic [ADDR_W-1:0] src_ptr,
   output logic [ADDR_W-1:0] dst_ptr,
   output logic [CNT_W-1:0]  byte_cnt,
   output logic              cnt_last,
   output logic              cnt_nz
);

   localparam int NPTR = 2;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [ADDR_W-1:0] ptr_q [NPTR];
   logic [1:0]        ptr_sel [NPTR];

   assign ptr_sel[0] = SEL_SRC;
   assign ptr_sel[1] = SEL_DST;

   for (genvar i = 0; i < NPTR; i++) begin : g_ptr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr_q[i] <= '0;
         end else if (step) begin
            if (desc) ptr_q[i] <= ptr_q[i] - 1'b1;
            else      ptr_q[i] <= ptr_q[i] + 1'b1;
         end else if (ld_en && ld_sel == ptr_sel[i]) begin
            ptr_q[i] <= ld_val[ADDR_W-1:0];
         end
      end
   end

   logic [CNT_W-1:0] cnt_q;
   logic             nz_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         nz_q  <= 1'b0;
      end else if (step) begin
         cnt_q <= cnt_q - 1'b1;
         nz_q  <= (cnt_q != CNT_ONE);
      end else if (ld_en && ld_sel == SEL_CNT) begin
         cnt_q <= ld_val[CNT_W-1:0];
         nz_q  <= (ld_val[CNT_W-1:0] != '0);
      end
   end

   assign src_ptr  = ptr_q[0];
   assign dst_ptr  = ptr_q[1];
   assign byte_cnt = cnt_q;
   assign cnt_last = (cnt_q == CNT_ONE);
   assign cnt_nz   = nz_q;

endmodule

// File: rtl/blkcopy_seq.sv
module blkcopy_seq
   import blkcopy_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rep_mode,
   input  logic desc_mode,
   input  logic rdy,
   input  logic cnt_last,
   output logic busy,
   output logic done,
   output logic desc,
   output logic rd,
   output logic wr,
   output logic capture,
   output logic step
);

   seq_state_e state_q;
   logic       rep_q;
   logic       desc_q;
   logic       done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rep_q   <= 1'b0;
         desc_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  rep_q   <= rep_mode;
                  desc_q  <= desc_mode;
                  state_q <= ST_READ;
               end
            end
            ST_READ: begin
               if (rdy) state_q <= ST_WRITE;
            end
            ST_WRITE: begin
               if (rdy) begin
                  if (rep_q && !cnt_last) begin
                     state_q <= ST_READ;
                  end else begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign done    = done_q;
   assign desc    = desc_q;
   assign rd      = (state_q == ST_READ);
   assign wr      = (state_q == ST_WRITE);
   assign capture = rd && rdy;
   assign step    = wr && rdy;

endmodule

// File: rtl/blkcopy_dbuf.sv
module blkcopy_dbuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   logic [DATA_W-1:0] buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       buf_q <= '0;
      else if (capture) buf_q <= din;
   end

   assign dout = buf_q;

endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
   import blkcopy_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int CNT_W    = 16,
   parameter int DATA_W   = 8,
   parameter bit READY_EN = 1'b1,
   parameter int LD_W     = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [1:0]        ld_sel,
   input  logic [LD_W-1:0]   ld_val,
   input  logic              start,
   input  logic              rep_mode,
   input  logic              desc_mode,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rdy,
   output logic              busy,
   output logic              done,
   output logic              cnt_nz,
   output logic [ADDR_W-1:0] src_ptr,
   output logic [ADDR_W-1:0] dst_ptr,
   output logic [CNT_W-1:0]  byte_cnt
);

   if (ADDR_W < 2 || CNT_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("blkcopy_engine: ADDR_W >= 2, CNT_W >= 1 and DATA_W >= 1 are required");
   end
   if (LD_W < ADDR_W || LD_W < CNT_W) begin : g_bad_ldw
      $error("blkcopy_engine: LD_W must cover ADDR_W and CNT_W");
   end

   logic rdy_eff;
   if (READY_EN) begin : g_rdy
      assign rdy_eff = mem_rdy;
   end else begin : g_no_rdy
      assign rdy_eff = 1'b1;
   end

   logic ld_ok;
   logic step;
   logic capture;
   logic desc;
   logic cnt_last;

   assign ld_ok = ld_en && !busy;

   blkcopy_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rep_mode  (rep_mode),
      .desc_mode (desc_mode),
      .rdy       (rdy_eff),
      .cnt_last  (cnt_last),
      .busy      (busy),
      .done      (done),
      .desc      (desc),
      .rd        (mem_rd),
      .wr        (mem_wr),
      .capture   (capture),
      .step      (step)
   );

   blkcopy_regs #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .LD_W   (LD_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ld_ok),
      .ld_sel   (ld_sel),
      .ld_val   (ld_val),
      .step     (step),
      .desc     (desc),
      .src_ptr  (src_ptr),
      .dst_ptr  (dst_ptr),
      .byte_cnt (byte_cnt),
      .cnt_last (cnt_last),
      .cnt_nz   (cnt_nz)
   );

   blkcopy_dbuf #(
      .DATA_W (DATA_W)
   ) u_dbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .din     (mem_rdata),
      .dout    (mem_wdata)
   );

   assign mem_addr = mem_wr ? dst_ptr : src_ptr;

endmodule

// File: rtl/blkcopy_chk.sv
module blkcopy_chk #(
   parameter int ADDR_W   = 16,
   parameter int CNT_W    = 16,
   parameter int DATA_W   = 8,
   parameter bit READY_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              mem_rdy,
   input logic              busy,
   input logic              done,
   input logic              cnt_nz,
   input logic [ADDR_W-1:0] src_ptr,
   input logic [ADDR_W-1:0] dst_ptr,
   input logic [CNT_W-1:0]  byte_cnt
);

   logic rdy_c;
   assign rdy_c = READY_EN ? mem_rdy : 1'b1;

   logic step_c;
   assign step_c = mem_wr && rdy_c;

   logic [DATA_W-1:0] last_rd;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 last_rd <= '0;
      else if (mem_rd && rdy_c)   last_rd <= mem_rdata;
   end

   p_rdwr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_wdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> mem_wdata == last_rd);

   p_cnt_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step_c |=> byte_cnt == CNT_W'($past(byte_cnt) - 1'b1));

   p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step_c |=> ((src_ptr == ADDR_W'($past(src_ptr) + 1'b1)) &&
                  (dst_ptr == ADDR_W'($past(dst_ptr) + 1'b1))) ||
                 ((src_ptr == ADDR_W'($past(src_ptr) - 1'b1)) &&
                  (dst_ptr == ADDR_W'($past(dst_ptr) - 1'b1))));

   p_nz_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      step_c |=> cnt_nz == (byte_cnt != '0));

   p_hold_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !rdy_c) |=> mem_rd && $stable(mem_addr));

   p_hold_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !rdy_c) |=> mem_wr && $stable(mem_addr) && $stable(mem_wdata));

   p_busy_regs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !step_c) |=> $stable(src_ptr) && $stable(dst_ptr) && $stable(byte_cnt));

   p_done_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy));

endmodule

bind blkcopy_engine blkcopy_chk #(
   .ADDR_W   (ADDR_W),
   .CNT_W    (CNT_W),
   .DATA_W   (DATA_W),
   .READY_EN (READY_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_rdata (mem_rdata),
   .mem_rdy   (mem_rdy),
   .busy      (busy),
   .done      (done),
   .cnt_nz    (cnt_nz),
   .src_ptr   (src_ptr),
   .dst_ptr   (dst_ptr),
   .byte_cnt  (byte_cnt)
);

// File: tb/tb_blkcopy_engine.sv
module tb_blkcopy_engine;

   localparam int AW    = 10;
   localparam int CW    = 8;
   localparam int DW    = 8;
   localparam int LW    = (AW > CW) ? AW : CW;
   localparam int MSZ   = 1 << AW;
   localparam int AMASK = MSZ - 1;
   localparam int CMASK = (1 << CW) - 1;
   localparam int NVEC  = 8;

   // vector: {src[31:22], dst[21:12], cnt[11:4], rep[3], desc[2], wait[1:0]}
   localparam logic [31:0] VEC [NVEC] = '{
      {10'h010, 10'h100, 8'd8, 1'b1, 1'b0, 2'd0},
      {10'h020, 10'h200, 8'd5, 1'b1, 1'b1, 2'd1},
      {10'h030, 10'h300, 8'd3, 1'b0, 1'b0, 2'd2},
      {10'h040, 10'h050, 8'd1, 1'b0, 1'b1, 2'd0},
      {10'h060, 10'h062, 8'd6, 1'b1, 1'b0, 2'd0},
      {10'h3FE, 10'h0F0, 8'd4, 1'b1, 1'b0, 2'd1},
      {10'h001, 10'h380, 8'd3, 1'b1, 1'b1, 2'd3},
      {10'h070, 10'h3A0, 8'd0, 1'b0, 1'b0, 2'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_en = 1'b0;
   logic [1:0]    ld_sel = 2'd3;
   logic [LW-1:0] ld_val = '0;
   logic          start = 1'b0;
   logic          rep_mode = 1'b0;
   logic          desc_mode = 1'b0;
   logic [AW-1:0] mem_addr;
   logic          mem_rd, mem_wr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic          mem_rdy;
   logic          busy, done, cnt_nz;
   logic [AW-1:0] src_ptr, dst_ptr;
   logic [CW-1:0] byte_cnt;

   always #10 clk = ~clk;

   blkcopy_engine #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW), .READY_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
      .start(start), .rep_mode(rep_mode), .desc_mode(desc_mode),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .busy(busy), .done(done),
      .cnt_nz(cnt_nz), .src_ptr(src_ptr), .dst_ptr(dst_ptr), .byte_cnt(byte_cnt)
   );

   // memory model with programmable wait cycles
   logic [DW-1:0] mem [MSZ];
   logic [DW-1:0] shadow [MSZ];
   logic [1:0]    wait_n = 2'd0;
   logic [1:0]    wait_q;
   logic          fill_go = 1'b0;
   int            fill_seed = 0;

   function automatic logic [DW-1:0] pat(int i, int seed);
      return DW'((i * 13) ^ (seed * 71) ^ (i >> 3));
   endfunction

   assign mem_rdy   = (mem_rd || mem_wr) && (wait_q == wait_n);
   assign mem_rdata = mem[mem_addr];

   always @(posedge clk) begin
      if (!rst_n || !(mem_rd || mem_wr) || mem_rdy) wait_q <= 2'd0;
      else                                          wait_q <= wait_q + 2'd1;
      if (fill_go) begin
         for (int i = 0; i < MSZ; i++) mem[i] <= pat(i, fill_seed);
      end else if (mem_wr && mem_rdy) begin
         mem[mem_addr] <= mem_wdata;
      end
   end

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic fill(int seed);
      @(negedge clk);
      fill_seed = seed;
      fill_go   = 1'b1;
      @(negedge clk);
      fill_go   = 1'b0;
      for (int i = 0; i < MSZ; i++) shadow[i] = pat(i, seed);
   endtask

   task automatic load(logic [1:0] sel, int val);
      @(negedge clk);
      ld_en  = 1'b1;
      ld_sel = sel;
      ld_val = LW'(val);
      @(negedge clk);
      ld_en  = 1'b0;
      ld_sel = 2'd3;
   endtask

   task automatic model(int s, int d, int c, bit rep, bit dsc,
                        output int se, output int de, output int ce);
      do begin
         shadow[d] = shadow[s];
         s = dsc ? ((s - 1) & AMASK) : ((s + 1) & AMASK);
         d = dsc ? ((d - 1) & AMASK) : ((d + 1) & AMASK);
         c = (c - 1) & CMASK;
      end while (rep && c != 0);
      se = s; de = d; ce = c;
   endtask

   task automatic pulse_start(bit rep, bit dsc);
      @(negedge clk);
      start = 1'b1; rep_mode = rep; desc_mode = dsc;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   task automatic mem_compare(string req);
      int bad = 0;
      for (int i = 0; i < MSZ; i++) if (mem[i] !== shadow[i]) bad++;
      check(req, "memory mismatches", bad, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      int se, de, ce;
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11", "busy", busy, 0);
      check("R11", "done", done, 0);
      check("R11", "cnt_nz", cnt_nz, 0);
      check("R11", "rd|wr", mem_rd | mem_wr, 0);
      check("R11", "regs", {src_ptr, dst_ptr, byte_cnt}, 0);
      rst_n = 1'b1;

      // R1 / R7: loads while idle
      load(2'd0, 'h155);
      load(2'd1, 'h2AA);
      load(2'd2, 'h33);
      check("R1", "src load", src_ptr, 'h155);
      check("R1", "dst load", dst_ptr, 'h2AA);
      check("R1", "cnt load", byte_cnt, 'h33);
      check("R7", "nz after nonzero load", cnt_nz, 1);
      load(2'd2, 0);
      check("R7", "nz after zero load", cnt_nz, 0);

      // table of vectors
      for (int v = 0; v < NVEC; v++) begin
         int s, d, c;
         bit rep, dsc;
         s = int'(VEC[v][31:22]); d = int'(VEC[v][21:12]); c = int'(VEC[v][11:4]);
         rep = VEC[v][3]; dsc = VEC[v][2];
         wait_n = VEC[v][1:0];
         fill(v + 1);
         load(2'd0, s); load(2'd1, d); load(2'd2, c);
         model(s, d, c, rep, dsc, se, de, ce);
         pulse_start(rep, dsc);
         check("R10", "busy after start", busy, 1);
         wait_done();
         check("R10", "busy at done", busy, 0);
         check(dsc ? "R4" : "R3", "src ptr", src_ptr, se);
         check(dsc ? "R4" : "R3", "dst ptr", dst_ptr, de);
         check(rep ? "R6" : "R5", "counter", byte_cnt, ce);
         check("R7", "cnt_nz", cnt_nz, ce != 0);
         mem_compare(wait_n != 0 ? "R8" : "R2");
         @(negedge clk);
         check("R10", "done width", done, 0);
      end

      // R6: zero count in repeat mode copies 2^CW bytes
      wait_n = 2'd0;
      fill(20);
      load(2'd0, 'h000); load(2'd1, 'h200); load(2'd2, 0);
      model('h000, 'h200, 0, 1'b1, 1'b0, se, de, ce);
      pulse_start(1'b1, 1'b0);
      wait_done();
      check("R6", "zero-count src", src_ptr, 'h100);
      check("R6", "zero-count cnt", byte_cnt, 0);
      mem_compare("R6");

      // R9 / R1: start and load while busy are ignored
      wait_n = 2'd1;
      fill(21);
      load(2'd0, 'h080); load(2'd1, 'h180); load(2'd2, 4);
      model('h080, 'h180, 4, 1'b1, 1'b0, se, de, ce);
      pulse_start(1'b1, 1'b0);
      @(negedge clk);
      start = 1'b1; rep_mode = 1'b0; desc_mode = 1'b1;
      ld_en = 1'b1; ld_sel = 2'd2; ld_val = LW'(50);
      @(negedge clk);
      start = 1'b0; ld_en = 1'b0; ld_sel = 2'd3;
      wait_done();
      check("R9", "src after ignored start", src_ptr, se);
      check("R9", "dst after ignored start", dst_ptr, de);
      check("R1", "cnt after load while busy", byte_cnt, ce);
      mem_compare("R9");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule